// File: doc/BRIEF.md
# Timer Compare/Capture Pin Controller

This block handles one general-purpose timer register and the pin tied to it. A 4-bit mode field picks what the register does. In compare mode the register is matched against a free-running counter. Writing the mode sets the pin to a chosen starting level. Each match then clears, sets or toggles the pin, and sets a sticky flag. In capture mode the register takes a copy of the counter value when a trigger occurs and sets the same flag. The trigger is a chosen edge of the synchronized pin input, or a count strobe from a neighbouring counter.

The counter value, the neighbour's count strobe and the neighbour's prescaler select all come from outside. Software writes the mode field and the register, reads both back, and clears the flag with a write-one-to-clear access. Counter generation, prescaling and interrupt routing are handled elsewhere.

Top module: `cmpcap_pin_ctrl`

## Requirements
- R1: After reset the mode field is 0000, the register is 0, the flag is 0, the pin level is 0 and pinOe is 0.
- R2: Mode codes 0001, 0010 and 0011 are output modes with starting level 0, and 0101, 0110 and 0111 are output modes with starting level 1. A mode write takes effect on the next clock edge. On that edge modeRd shows the written code, the pin takes the starting level, and pinOe goes high.
- R3: In compare modes (mode bit 3 = 0), a match is a cycle in which cntVal equals the register. On the edge that ends that cycle, the flag is set and the pin acts on mode bits 1:0: 01 drives 0, 10 drives 1, 11 toggles.
- R4: Codes 0000 and 0100 hold pinOe low and keep the register as a compare register. A match still sets the flag, and the pin level does not change. Writing either code does not load a starting level.
- R5: Codes 10xx capture from the pin. Low bits 00 select the rising edge, 01 the falling edge, and 1x both edges. The pin passes through a two-stage synchronizer. On the third rising clock edge after the pin changes, the register takes cntVal and the flag is set. An edge of the unselected polarity has no effect, and pinOe is low.
- R6: Codes 11xx capture on the neighbour counter's count strobe. On the edge that ends each cycle with nbrCount high, the register takes cntVal and the flag is set. Mode bits 1:0 have no effect.
- R7: When nbrPrescSel is 000, a neighbour count strobe causes no capture: the register and the flag stay unchanged.
- R8: A cycle with flagWr high and flagWrData = 1 clears the flag on the next edge, and flagWrData = 0 leaves it unchanged. A match or capture in the same cycle wins, and the flag stays set.
- R9: A cycle with regWrEn high loads regWrData into the register, and regRd shows it after the next edge.
- R10: In capture modes, cntVal equal to the register neither sets the flag nor changes the pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | CNT_W | Current counter value |
| modeWrEn | input | 1 | Mode field write strobe |
| modeWrData | input | 4 | Mode code to write |
| modeRd | output | 4 | Mode field readback |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | CNT_W | Register write data |
| regRd | output | CNT_W | Register readback |
| flagWr | input | 1 | Flag write strobe |
| flagWrData | input | 1 | Flag write data, 1 clears |
| pinIn | input | 1 | Asynchronous pin input |
| nbrCount | input | 1 | Neighbour counter count strobe |
| nbrPrescSel | input | 3 | Neighbour counter prescaler select |
| pinOut | output | 1 | Pin output level |
| pinOe | output | 1 | Pin drive enable |
| flag | output | 1 | Sticky match/capture flag |

## Verification
Mode, register and flag writes each take effect one edge after their strobe cycle. A compare match shows on the pin and the flag one edge after the cycle of equality, and a neighbour strobe causes a capture one edge later. A pin change reaches the register on the third edge because of the two synchronizer stages and the previous-sample stage. The bench drives every input on the falling edge and counts rising edges to the falling edge where each result is due. For pin captures it also checks, one falling edge early, that the flag has not yet been set.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;

  localparam int MODE_W  = 4;
  localparam int PRESC_W = 3;

  // Pin action on compare match, encoded as mode bits 1:0
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TGL  = 2'b11
  } matchAct_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10
  } edgeSel_e;

  // Decoded view of the current mode code
  typedef struct packed {
    logic      cmpMode;
    logic      drvOut;
    matchAct_e act;
    logic      pinCap;
    logic      nbrCap;
    edgeSel_e  edgeSel;
  } modeDec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadInit;
    logic      initLvl;
    logic      matchHit;
    matchAct_e act;
    logic      capture;
    logic      clrFlag;
  } ctrlStb_t;

  function automatic modeDec_t decodeMode(logic [MODE_W-1:0] m);
    modeDec_t d;
    d.cmpMode = ~m[3];
    d.drvOut  = ~m[3] && (m[1:0] != 2'b00);
    d.act     = m[3] ? ACT_HOLD : matchAct_e'(m[1:0]);
    d.pinCap  = m[3] & ~m[2];
    d.nbrCap  = m[3] & m[2];
    if (m[1])      d.edgeSel = EDGE_BOTH;
    else if (m[0]) d.edgeSel = EDGE_FALL;
    else           d.edgeSel = EDGE_RISE;
    return d;
  endfunction

endpackage

// File: rtl/cmpcap_ctrl.sv
module cmpcap_ctrl
  import cmpcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeWrEn,
  input  logic [MODE_W-1:0]  modeWrData,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic [CNT_W-1:0]   grVal,
  input  logic               pinIn,
  input  logic               nbrCount,
  input  logic [PRESC_W-1:0] nbrPrescSel,
  input  logic               flagWr,
  input  logic               flagWrData,
  output logic [MODE_W-1:0]  modeQ,
  output logic               pinOe,
  output ctrlStb_t           stb
);

  // Synchronizer stages plus one previous-sample stage
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] syncQ;
  modeDec_t          curDec;
  logic              pinCur, pinPrev, riseSeen, fallSeen;
  logic              pinHit, nbrHit, wrIsOutput;

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= '0;
    else if (modeWrEn) modeQ <= modeWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[HIST_W-2:0], pinIn};
  end

  assign curDec   = decodeMode(modeQ);
  assign pinCur   = syncQ[SYNC_STAGES-1];
  assign pinPrev  = syncQ[SYNC_STAGES];
  assign riseSeen = pinCur & ~pinPrev;
  assign fallSeen = ~pinCur & pinPrev;

  always_comb begin
    unique case (curDec.edgeSel)
      EDGE_RISE: pinHit = riseSeen;
      EDGE_FALL: pinHit = fallSeen;
      default:   pinHit = riseSeen | fallSeen;
    endcase
    pinHit = pinHit & curDec.pinCap;
  end

  assign nbrHit     = curDec.nbrCap && nbrCount && (nbrPrescSel != '0);
  assign wrIsOutput = modeWrEn && !modeWrData[3] && (modeWrData[1:0] != 2'b00);

  always_comb begin
    stb.loadInit = wrIsOutput;
    stb.initLvl  = modeWrData[2];
    stb.matchHit = curDec.cmpMode && (cntVal == grVal);
    stb.act      = curDec.act;
    stb.capture  = pinHit | nbrHit;
    stb.clrFlag  = flagWr & flagWrData;
  end

  assign pinOe = curDec.drvOut;

  assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> modeQ == $past(modeWrData));

  assert_oe_off_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[1:0] == 2'b00) |-> !pinOe);

  assert_presc_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[3:2] == 2'b11 && nbrPrescSel == '0) |-> !stb.capture);

  assert_no_cmp_in_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    modeQ[3] |-> (!stb.matchHit && !pinOe));

endmodule

// File: rtl/cmpcap_dp.sv
module cmpcap_dp
  import cmpcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] grQ,
  output logic             pinLvl,
  output logic             flagQ
);

  logic setFlag;
  logic pinNext;

  assign setFlag = stb.matchHit | stb.capture;

  // Capture has priority over a software write in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)            grQ <= '0;
    else if (stb.capture) grQ <= cntVal;
    else if (regWrEn)     grQ <= regWrData;
  end

  always_comb begin
    pinNext = pinLvl;
    if (stb.loadInit) begin
      pinNext = stb.initLvl;
    end else if (stb.matchHit) begin
      unique case (stb.act)
        ACT_CLR:  pinNext = 1'b0;
        ACT_SET:  pinNext = 1'b1;
        ACT_TGL:  pinNext = ~pinLvl;
        default:  pinNext = pinLvl;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinLvl <= 1'b0;
    else       pinLvl <= pinNext;
  end

  // Setting the flag wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (setFlag)     flagQ <= 1'b1;
    else if (stb.clrFlag) flagQ <= 1'b0;
  end

  assert_init_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadInit |=> pinLvl == $past(stb.initLvl));

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.matchHit && !stb.loadInit && stb.act == ACT_TGL) |=> pinLvl != $past(pinLvl));

  assert_pin_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadInit && !(stb.matchHit && stb.act != ACT_HOLD)) |=> $stable(pinLvl));

  assert_capture_value_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (grQ == $past(cntVal)) && flagQ);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrFlag && !stb.matchHit && !stb.capture) |=> !flagQ);

  assert_flag_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.matchHit || stb.capture) |=> flagQ);

  assert_reg_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !stb.capture) |=> grQ == $past(regWrData));

endmodule

// File: rtl/cmpcap_pin_ctrl.sv
module cmpcap_pin_ctrl
  import cmpcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   cntVal,
  input  logic               modeWrEn,
  input  logic [MODE_W-1:0]  modeWrData,
  output logic [MODE_W-1:0]  modeRd,
  input  logic               regWrEn,
  input  logic [CNT_W-1:0]   regWrData,
  output logic [CNT_W-1:0]   regRd,
  input  logic               flagWr,
  input  logic               flagWrData,
  input  logic               pinIn,
  input  logic               nbrCount,
  input  logic [PRESC_W-1:0] nbrPrescSel,
  output logic               pinOut,
  output logic               pinOe,
  output logic               flag
);

  ctrlStb_t stb;

  cmpcap_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) ctrlInst (
    .clk         (clk),
    .rstN        (rstN),
    .modeWrEn    (modeWrEn),
    .modeWrData  (modeWrData),
    .cntVal      (cntVal),
    .grVal       (regRd),
    .pinIn       (pinIn),
    .nbrCount    (nbrCount),
    .nbrPrescSel (nbrPrescSel),
    .flagWr      (flagWr),
    .flagWrData  (flagWrData),
    .modeQ       (modeRd),
    .pinOe       (pinOe),
    .stb         (stb)
  );

  cmpcap_dp #(.CNT_W(CNT_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cntVal    (cntVal),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .grQ       (regRd),
    .pinLvl    (pinOut),
    .flagQ     (flag)
  );

endmodule

// File: tb/cmpcap_pin_ctrl_test.sv
module cmpcap_pin_ctrl_test;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic [CNT_W-1:0] cntVal;
  logic             modeWrEn;
  logic [3:0]       modeWrData;
  logic [3:0]       modeRd;
  logic             regWrEn;
  logic [CNT_W-1:0] regWrData;
  logic [CNT_W-1:0] regRd;
  logic             flagWr;
  logic             flagWrData;
  logic             pinIn;
  logic             nbrCount;
  logic [2:0]       nbrPrescSel;
  logic             pinOut;
  logic             pinOe;
  logic             flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cmpcap_pin_ctrl #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .cntVal(cntVal),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .modeRd(modeRd),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRd(regRd),
    .flagWr(flagWr), .flagWrData(flagWrData),
    .pinIn(pinIn), .nbrCount(nbrCount), .nbrPrescSel(nbrPrescSel),
    .pinOut(pinOut), .pinOe(pinOe), .flag(flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [3:0] m);
    @(negedge clk); modeWrEn = 1'b1; modeWrData = m;
    @(negedge clk); modeWrEn = 1'b0;
  endtask

  task automatic writeReg(input logic [CNT_W-1:0] v);
    @(negedge clk); regWrEn = 1'b1; regWrData = v;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); flagWr = 1'b1; flagWrData = 1'b1;
    @(negedge clk); flagWr = 1'b0; flagWrData = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 mode", modeRd, 0);
    chk("R1 reg", regRd, 0);
    chk("R1 flag", flag, 0);
    chk("R1 pin", pinOut, 0);
    chk("R1 oe", pinOe, 0);
  endtask

  task automatic testRegWrite();
    writeReg(16'd20);
    chk("R9 reg write", regRd, 20);
  endtask

  // Register holds 20; the counter visits 20 for one cycle
  task automatic testCompare(input logic [3:0] m, input logic initL, input logic expL);
    @(negedge clk); cntVal = 16'd5;
    clearFlag();
    writeMode(m);
    chk("R2 mode readback", modeRd, int'(m));
    chk("R2 oe", pinOe, 1);
    chk("R2 initial level", pinOut, int'(initL));
    chk("R3 flag before match", flag, 0);
    cntVal = 16'd20;
    @(negedge clk);
    chk("R3 pin after match", pinOut, int'(expL));
    chk("R3 flag after match", flag, 1);
    cntVal = 16'd21;
    @(negedge clk);
    chk("R3 pin stays", pinOut, int'(expL));
  endtask

  task automatic testDisabled();
    @(negedge clk); cntVal = 16'd5;
    writeMode(4'b0100);
    chk("R4 oe off", pinOe, 0);
    chk("R4 no initial load", pinOut, 1);
    clearFlag();
    cntVal = 16'd20;
    @(negedge clk);
    chk("R4 flag on match", flag, 1);
    chk("R4 pin unchanged", pinOut, 1);
    cntVal = 16'd5;
  endtask

  task automatic pinEdge(input logic newVal, input logic [CNT_W-1:0] cnt,
                         input bit expCap, input string tag);
    int expReg;
    expReg = expCap ? int'(cnt) : int'(regRd);
    @(negedge clk); pinIn = newVal; cntVal = cnt;
    repeat (2) @(negedge clk);
    chk({tag, " flag not yet"}, flag, 0);
    @(negedge clk);
    chk({tag, " reg"}, regRd, expReg);
    chk({tag, " flag"}, flag, expCap ? 1 : 0);
    clearFlag();
  endtask

  task automatic testPinCapture();
    @(negedge clk); cntVal = 16'd5;
    writeMode(4'b1000);
    clearFlag();
    chk("R5 oe off", pinOe, 0);
    pinEdge(1'b1, 16'd100, 1'b1, "R5 rise mode rising");
    pinEdge(1'b0, 16'd110, 1'b0, "R5 rise mode falling");
    writeMode(4'b1001);
    pinEdge(1'b1, 16'd120, 1'b0, "R5 fall mode rising");
    pinEdge(1'b0, 16'd130, 1'b1, "R5 fall mode falling");
    writeMode(4'b1010);
    pinEdge(1'b1, 16'd140, 1'b1, "R5 both mode rising");
    pinEdge(1'b0, 16'd150, 1'b1, "R5 both mode falling");
    writeMode(4'b1011);
    pinEdge(1'b1, 16'd160, 1'b1, "R5 both mode 11 rising");
  endtask

  task automatic testCaptureNoCompare();
    logic pinBefore;
    pinBefore = pinOut;
    clearFlag();
    cntVal = regRd;
    repeat (3) @(negedge clk);
    chk("R10 no match flag", flag, 0);
    chk("R10 pin unchanged", pinOut, int'(pinBefore));
    cntVal = 16'd5;
  endtask

  task automatic nbrPulse(input logic [CNT_W-1:0] cnt, input logic withClr);
    @(negedge clk); cntVal = cnt; nbrCount = 1'b1;
    flagWr = withClr; flagWrData = withClr;
    @(negedge clk); nbrCount = 1'b0; flagWr = 1'b0; flagWrData = 1'b0;
  endtask

  task automatic testNeighbour();
    nbrPrescSel = 3'b001;
    writeMode(4'b1100);
    clearFlag();
    nbrPulse(16'd300, 1'b0);
    chk("R6 reg code 1100", regRd, 300);
    chk("R6 flag code 1100", flag, 1);
    clearFlag();
    writeMode(4'b1111);
    nbrPulse(16'd310, 1'b0);
    chk("R6 reg code 1111", regRd, 310);
    chk("R6 flag code 1111", flag, 1);
    clearFlag();
    nbrPrescSel = 3'b000;
    nbrPulse(16'd320, 1'b0);
    chk("R7 reg unchanged", regRd, 310);
    chk("R7 flag unchanged", flag, 0);
    nbrPrescSel = 3'b010;
  endtask

  task automatic testFlagClear();
    nbrPulse(16'd330, 1'b0);
    chk("R8 flag set", flag, 1);
    @(negedge clk); flagWr = 1'b1; flagWrData = 1'b0;
    @(negedge clk); flagWr = 1'b0;
    chk("R8 write zero keeps flag", flag, 1);
    clearFlag();
    chk("R8 write one clears", flag, 0);
    nbrPulse(16'd340, 1'b1);
    chk("R8 set wins reg", regRd, 340);
    chk("R8 set wins flag", flag, 1);
    clearFlag();
    chk("R8 cleared again", flag, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cntVal = 16'd5;
    modeWrEn = 1'b0; modeWrData = '0;
    regWrEn = 1'b0; regWrData = '0;
    flagWr = 1'b0; flagWrData = 1'b0;
    pinIn = 1'b0; nbrCount = 1'b0; nbrPrescSel = 3'b001;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegWrite();
    testCompare(4'b0001, 1'b0, 1'b0);
    testCompare(4'b0010, 1'b0, 1'b1);
    testCompare(4'b0011, 1'b0, 1'b1);
    testCompare(4'b0101, 1'b1, 1'b0);
    testCompare(4'b0111, 1'b1, 1'b0);
    testCompare(4'b0110, 1'b1, 1'b1);
    testDisabled();
    testPinCapture();
    testCaptureNoCompare();
    testNeighbour();
    testFlagClear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule